// File: doc/BRIEF.md
# Timing-module command register file

This block is the command decoder and register store of a four-channel timing module that sits on a crate bus. A function code and a subaddress are presented with a one-cycle command strobe. Together they select one of several operations:

- read or write half of a channel's 32-bit packed delay register,
- enable or disable a channel,
- read the live status word or the latched attention word,
- read the module identity, version and configuration,
- clear the attention latches,
- reset the module.

Read data and the Q (command accepted) response are combinational. They are valid while the strobe is high. Writes and control commands take effect on the clock edge that ends the strobe cycle.

Three monitor inputs are sampled on every clock: beam-clock present, event-clock present and PLL unlocked. A failure seen on any of them is caught by a sticky latch. A loss of either clock raises the attention (LAM) request. The latches stay set until a clear command or a module reset. A fault that is still present after a clear is caught again on the following clock. The delay words are driven out as one flat bus to the timing channels.

Top module: `dly_regfile`

## Requirements
- R1: A strobed function 16 with subaddress 0–7 writes `wdata` into the delay register of channel `subaddr>>1`. An even subaddress loads register bits 15..0 and an odd subaddress loads bits 31..16, so the high word carries fine delay in bits 31..27, bucket delay in bits 26..24 and coarse delay bits 23..16. Channel c's register appears on `delay_bus[32c+31:32c]`.
- R2: A strobed function 0 with subaddress 0–7 returns the low (even) or high (odd) word of that channel's register on `rdata` with `q_ack`=1.
- R3: Function 26 with subaddress 0–3 sets the enable of that channel, and function 24 with subaddress 0–3 clears it. The other enables are untouched.
- R4: Function 1 subaddress 0 returns status with `q_ack`=1:
  - bit 0 beam clock present
  - bit 1 event clock present
  - bit 2 PLL unlocked
  - bit 3 inhibit
  - bits 7..4 channel timing flags
  - bits 11..8 armed flags
  - bits 15..12 enables
- R5: Function 1 subaddress 1 returns the attention word with `q_ack`=1:
  - bit 0 latched beam-clock loss
  - bit 1 latched event-clock loss
  - bit 2 latched PLL unlock
  - bit 3 live inhibit
  - bit 4 LAM
  - bit 14 the event-clock-used parameter
  - bit 15 the fast-beam-clock parameter
  - all other bits 0
- R6: A clock loss or PLL unlock seen at a clock edge sets its latch, and the latch holds after the fault goes away. `lam_req` and LAM bit 4 are 1 exactly when a clock-loss latch is set. A PLL latch alone does not raise them.
- R7: Function 10 subaddress 0 clears all three latches at its edge. A fault still present then sets its latch again at the next edge.
- R8: Asserting `rst_n` low, or a strobed function 9 subaddress 0, clears all enables, all delay registers and all latches.
- R9: Function 6 returns one of three words, each with `q_ack`=1:
  - subaddress 0: the identity 0x01DF
  - subaddress 1: the VERSION parameter
  - subaddress 2: the configuration word, with FINE_MASK in bits 3..0, OR_MASK in bits 7..4, event-clock-used in bit 14 and fast-beam-clock in bit 15
- R10: Any other function/subaddress pair gives `rdata`=0 and `q_ack`=0 and changes no state. Writes and control commands give `q_ack`=1 with `rdata`=0. With the strobe low nothing changes and `q_ack`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| fcode | input | 5 | Function code |
| subaddr | input | 4 | Subaddress |
| wdata | input | 16 | Write data |
| bs_ok | input | 1 | Beam clock present |
| tc_ok | input | 1 | Event clock present |
| pll_unlock | input | 1 | PLL not locked |
| inhibit | input | 1 | Output inhibit active |
| ch_timing | input | 4 | Per-channel timing-in-progress flags |
| ch_armed | input | 4 | Per-channel armed flags |
| rdata | output | 16 | Read data |
| q_ack | output | 1 | Command recognized |
| ch_enable | output | 4 | Channel enables |
| delay_bus | output | 128 | Four packed 32-bit delay registers |
| lam_req | output | 1 | Attention request |

## Verification
Every one of the 512 function/subaddress pairs is issued in turn, each carrying a distinct data word. Each pair's Q and read data are compared with a model. This separates recognized codes from the unused space and exposes any decode that aliases across subaddress bits.

Delay words are written per channel with field values that differ in every bit group. This shows that the two halves land in the right channel and that the fine, bucket and coarse fields sit at their positions.

Fault pulses on each monitor show the difference between a live and a latched bit. A clear issued during a persistent fault shows the one-cycle gap before the latch sets again. A fault pulse on the PLL input alone shows that this latch does not raise LAM.

// File: rtl/dly_regfile.sv
module dly_regfile #(
  parameter logic [15:0] VERSION   = 16'h0110,
  parameter logic [3:0]  FINE_MASK = 4'b1011,
  parameter logic [3:0]  OR_MASK   = 4'b0110,
  parameter bit          TCLK_USED = 1'b1,
  parameter bit          FAST_BS   = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_stb,
  input  logic [4:0]   fcode,
  input  logic [3:0]   subaddr,
  input  logic [15:0]  wdata,
  input  logic         bs_ok,
  input  logic         tc_ok,
  input  logic         pll_unlock,
  input  logic         inhibit,
  input  logic [3:0]   ch_timing,
  input  logic [3:0]   ch_armed,
  output logic [15:0]  rdata,
  output logic         q_ack,
  output logic [3:0]   ch_enable,
  output logic [127:0] delay_bus,
  output logic         lam_req
);
  localparam int NCH = 4;
  localparam int DW = 32;
  localparam logic [15:0] MOD_ID = 16'h01DF;

  logic [DW-1:0] dly [NCH];
  logic lat_bs, lat_tc, lat_pll;

  wire       lo8    = (subaddr[3] == 1'b0);
  wire       lo4    = (subaddr[3:2] == 2'b00);
  wire [1:0] wsel   = subaddr[2:1];
  wire       do_wr  = cmd_stb && fcode == 5'd16 && lo8;
  wire       do_rd  = cmd_stb && fcode == 5'd0  && lo8;
  wire       do_en  = cmd_stb && fcode == 5'd26 && lo4;
  wire       do_dis = cmd_stb && fcode == 5'd24 && lo4;
  wire       do_rst = cmd_stb && fcode == 5'd9  && subaddr == 4'd0;
  wire       do_clr = cmd_stb && fcode == 5'd10 && subaddr == 4'd0;
  wire       do_st  = cmd_stb && fcode == 5'd1  && subaddr == 4'd0;
  wire       do_lam = cmd_stb && fcode == 5'd1  && subaddr == 4'd1;
  wire       do_id  = cmd_stb && fcode == 5'd6  && subaddr <= 4'd2;

  assign lam_req = lat_bs | lat_tc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) dly[i] <= '0;
      ch_enable <= '0;
    end else if (do_rst) begin
      for (int i = 0; i < NCH; i++) dly[i] <= '0;
      ch_enable <= '0;
    end else begin
      if (do_wr) begin
        if (subaddr[0]) dly[wsel][31:16] <= wdata;
        else            dly[wsel][15:0]  <= wdata;
      end
      if (do_en)  ch_enable[subaddr[1:0]] <= 1'b1;
      if (do_dis) ch_enable[subaddr[1:0]] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_bs <= 1'b0; lat_tc <= 1'b0; lat_pll <= 1'b0;
    end else if (do_rst || do_clr) begin
      lat_bs <= 1'b0; lat_tc <= 1'b0; lat_pll <= 1'b0;
    end else begin
      lat_bs  <= lat_bs  | ~bs_ok;
      lat_tc  <= lat_tc  | ~tc_ok;
      lat_pll <= lat_pll | pll_unlock;
    end
  end

  always_comb begin
    rdata = '0;
    if (do_rd)
      rdata = subaddr[0] ? dly[wsel][31:16] : dly[wsel][15:0];
    else if (do_st)
      rdata = {ch_enable, ch_armed, ch_timing, inhibit, pll_unlock, tc_ok, bs_ok};
    else if (do_lam)
      rdata = {FAST_BS, TCLK_USED, 9'd0, lam_req, inhibit, lat_pll, lat_tc, lat_bs};
    else if (do_id)
      case (subaddr[1:0])
        2'd0:    rdata = MOD_ID;
        2'd1:    rdata = VERSION;
        default: rdata = {FAST_BS, TCLK_USED, 6'd0, OR_MASK, FINE_MASK};
      endcase
  end

  assign q_ack = do_rd | do_st | do_lam | do_id | do_wr | do_en | do_dis | do_rst | do_clr;

  for (genvar c = 0; c < NCH; c++) begin : g_bus
    assign delay_bus[c*DW +: DW] = dly[c];
  end
endmodule

module dly_regfile_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_stb,
  input logic [4:0]   fcode,
  input logic [3:0]   subaddr,
  input logic [15:0]  wdata,
  input logic         bs_ok,
  input logic         tc_ok,
  input logic [15:0]  rdata,
  input logic         q_ack,
  input logic [3:0]   ch_enable,
  input logic [127:0] delay_bus,
  input logic         lam_req
);
  wire clr_any = cmd_stb && (fcode == 5'd10 || fcode == 5'd9) && subaddr == 4'd0;

  p_wr_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && fcode == 5'd16 && subaddr == 4'd0) |=> delay_bus[15:0] == $past(wdata));
  p_wr_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && fcode == 5'd16 && subaddr == 4'd7) |=> delay_bus[127:112] == $past(wdata));
  p_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && fcode == 5'd26 && subaddr[3:2] == 2'b00) |=> ch_enable[$past(subaddr[1:0])]);
  p_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && fcode == 5'd24 && subaddr[3:2] == 2'b00) |=> !ch_enable[$past(subaddr[1:0])]);
  p_bs_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bs_ok && !clr_any) |=> lam_req);
  p_tc_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_ok && !clr_any) |=> lam_req);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> !lam_req);
  p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && fcode == 5'd9 && subaddr == 4'd0) |=> (ch_enable == 4'd0 && delay_bus == '0));
  p_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && fcode == 5'd6 && subaddr == 4'd0) |-> (q_ack && rdata == 16'h01DF));
  p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && fcode == 5'd2) |-> (!q_ack && rdata == 16'd0));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |=> ($stable(ch_enable) && $stable(delay_bus)));
endmodule

bind dly_regfile dly_regfile_chk u_chk (.*);

// File: tb/dly_regfile_test.sv
module dly_regfile_test;
  localparam logic [15:0] VER = 16'h0110;
  localparam logic [3:0]  FM  = 4'b1011;
  localparam logic [3:0]  OM  = 4'b0110;

  logic clk = 0, rst_n = 0, cmd_stb = 0;
  logic [4:0] fcode = 0;
  logic [3:0] subaddr = 0;
  logic [15:0] wdata = 0;
  logic bs_ok = 1, tc_ok = 1, pll_unlock = 0, inhibit = 1;
  logic [3:0] ch_timing = 4'h5, ch_armed = 4'hA;
  logic [15:0] rdata;
  logic q_ack;
  logic [3:0] ch_enable;
  logic [127:0] delay_bus;
  logic lam_req;

  logic [31:0] mdly [4];
  logic [3:0] men;
  logic mbs, mtc, mpll;
  int total = 0, bad = 0;

  dly_regfile #(.VERSION(VER), .FINE_MASK(FM), .OR_MASK(OM), .TCLK_USED(1'b1), .FAST_BS(1'b1)) uut (.*);

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] expect_rd(input int f, input int a);
    logic [15:0] d = 0;
    logic q = 0;
    if (f == 0 && a < 8) begin q = 1; d = a[0] ? mdly[a>>1][31:16] : mdly[a>>1][15:0]; end
    else if (f == 1 && a == 0) begin q = 1; d = {men, ch_armed, ch_timing, inhibit, pll_unlock, tc_ok, bs_ok}; end
    else if (f == 1 && a == 1) begin q = 1; d = {2'b11, 9'd0, mbs | mtc, inhibit, mpll, mtc, mbs}; end
    else if (f == 6 && a == 0) begin q = 1; d = 16'h01DF; end
    else if (f == 6 && a == 1) begin q = 1; d = VER; end
    else if (f == 6 && a == 2) begin q = 1; d = {2'b11, 6'd0, OM, FM}; end
    else if ((f == 16 && a < 8) || ((f == 24 || f == 26) && a < 4) || ((f == 9 || f == 10) && a == 0)) q = 1;
    return {q, d};
  endfunction

  task automatic model_step(input int f, input int a, input logic [15:0] d);
    if (f == 16 && a < 8) begin
      if (a[0]) mdly[a>>1][31:16] = d; else mdly[a>>1][15:0] = d;
    end
    if (f == 26 && a < 4) men[a] = 1'b1;
    if (f == 24 && a < 4) men[a] = 1'b0;
    if ((f == 9 || f == 10) && a == 0) begin mbs = 0; mtc = 0; mpll = 0; end
    else begin mbs |= ~bs_ok; mtc |= ~tc_ok; mpll |= pll_unlock; end
    if (f == 9 && a == 0) begin men = 0; for (int i = 0; i < 4; i++) mdly[i] = 0; end
  endtask

  // drive at negedge, sample mid-low phase, commit at posedge, return at next negedge
  task automatic cmd(input string req, input int f, input int a, input logic [15:0] d);
    logic [16:0] e;
    cmd_stb = 1; fcode = f[4:0]; subaddr = a[3:0]; wdata = d;
    #2;
    e = expect_rd(f, a);
    chk(req, {111'd0, q_ack, rdata}, {111'd0, e});
    @(posedge clk);
    model_step(f, a, d);
    @(negedge clk);
    cmd_stb = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step(31, 15, 0);
      @(negedge clk);
    end
  endtask

  task automatic chk_state(input string req);
    logic [127:0] eb;
    for (int i = 0; i < 4; i++) eb[i*32 +: 32] = mdly[i];
    #2;
    chk(req, delay_bus, eb);
    chk(req, {124'd0, ch_enable}, {124'd0, men});
    chk(req, {127'd0, lam_req}, {127'd0, mbs | mtc});
  endtask

  initial begin
    men = 0; mbs = 0; mtc = 0; mpll = 0;
    for (int i = 0; i < 4; i++) mdly[i] = 0;
    #35;
    chk_state("R8 reset state");
    chk("R10 idle q", {127'd0, q_ack}, 128'd0);
    rst_n = 1;
    @(negedge clk);

    // R10 R2 R4 R5 R9: full sweep of every function/subaddress pair
    for (int f = 0; f < 32; f++)
      for (int a = 0; a < 16; a++)
        cmd("R10 sweep", f, a, 16'((f * 16'h0961 + a * 16'h3A17) ^ 16'hC35A));
    chk_state("R10 state after sweep");

    // R1: packed fields per channel
    for (int c = 0; c < 4; c++) begin
      logic [23:0] dc = 24'hABCDE0 + 24'(c);
      logic [2:0]  dh = 3'(c + 3);
      logic [4:0]  df = 5'(19 + c);
      cmd("R1 low word", 16, 2 * c, dc[15:0]);
      cmd("R1 high word", 16, 2 * c + 1, {df, dh, dc[23:16]});
      #2;
      chk("R1 fine field", {123'd0, delay_bus[c*32+27 +: 5]}, {123'd0, df});
      chk("R1 bucket field", {125'd0, delay_bus[c*32+24 +: 3]}, {125'd0, dh});
      chk("R1 coarse field", {104'd0, delay_bus[c*32 +: 24]}, {104'd0, dc});
    end
    for (int a = 0; a < 8; a++) cmd("R2 readback", 0, a, 16'h0);

    // R10: strobe low ignored
    cmd_stb = 0; fcode = 16; subaddr = 0; wdata = 16'hDEAD;
    #2 chk("R10 no strobe q", {127'd0, q_ack}, 128'd0);
    fcode = 24; idle(2);
    chk_state("R10 no strobe state");

    // R3: enable patterns
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 4; c++) cmd("R3 set", p[c] ? 26 : 24, c, 16'h0);
      chk_state("R3 enable pattern");
      cmd("R4 status", 1, 0, 16'h0);
    end

    // R6: monitor pulses
    pll_unlock = 1; idle(1); pll_unlock = 0; idle(1);
    chk_state("R6 pll alone no lam");
    cmd("R5 lam word pll", 1, 1, 16'h0);
    bs_ok = 0; idle(1);
    cmd("R4 status live loss", 1, 0, 16'h0);
    bs_ok = 1; idle(2);
    chk_state("R6 beam loss held");
    cmd("R5 lam word beam", 1, 1, 16'h0);
    cmd("R7 clear", 10, 0, 16'h0);
    chk_state("R7 cleared");
    tc_ok = 0; idle(1);
    chk_state("R6 event loss");
    cmd("R7 clear during fault", 10, 0, 16'h0);
    chk_state("R7 gap after clear");
    idle(1);
    chk_state("R7 relatch");
    cmd("R5 lam word event", 1, 1, 16'h0);
    tc_ok = 1;

    // R8: module reset command, then hardware reset
    cmd("R8 reset cmd", 9, 0, 16'h0);
    chk_state("R8 after reset cmd");
    cmd("R1 write", 16, 5, 16'h1234);
    cmd("R3 enable", 26, 2, 16'h0);
    bs_ok = 0; idle(1); bs_ok = 1;
    rst_n = 0;
    men = 0; mbs = 0; mtc = 0; mpll = 0;
    for (int i = 0; i < 4; i++) mdly[i] = 0;
    chk_state("R8 hw reset");
    @(negedge clk) rst_n = 1;
    idle(1);
    chk_state("R8 after hw reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule